// File: doc/BRIEF.md
# Interrupt Acceptance and Mask Unit

This unit sits between the interrupt priority logic and the processor core's exception sequencer. Each cycle it compares the winning interrupt request against the 4-bit interrupt mask held in the core's status register. It decides whether the core takes the request now. A non-maskable request is always taken. A maskable request is taken only when its priority level is strictly above the current mask.

When a request is taken, the unit gives a one-cycle accept pulse and latches the vector number to fetch. It also latches the mask value the core must write back into the status register. That value is the accepted level, or all ones for the non-maskable request. From the accept onward, the unit holds its entry-active output high. This tells the sequencer to save the status register and program counter, fetch the handler address and hold instruction issue. It stays high until the sequencer reports completion, and no new request is sampled during that time.

Top module: `irq_accept_unit`

## Requirements
- R1: After synchronous reset, `accept`, `entry_active`, `taken_nmi`, `accept_vector` and `new_mask` are all 0.
- R2: A non-maskable request presented while the unit is idle is accepted on the next clock edge whatever the value of `sr_mask`, including 15.
- R3: A maskable request presented while idle is accepted only when `mi_level` is strictly greater than `sr_mask`; equal or lower levels give no accept.
- R4: On acceptance `new_mask` becomes `mi_level` for a maskable request and 15 (all four bits set) for the non-maskable request, and `taken_nmi` is 1 exactly for the non-maskable case.
- R5: When the non-maskable and a maskable request are both present in the same idle cycle, the non-maskable one is taken and `accept_vector` equals the parameter `NMI_VECTOR` (default 11); a maskable acceptance gives `accept_vector` = `mi_vector`.
- R6: `accept` is high for exactly one cycle per acceptance; `accept_vector`, `new_mask` and `taken_nmi` hold their values until the next acceptance.
- R7: `entry_active` rises together with `accept` and stays high until the cycle after `seq_done` is sampled high; no request is accepted while it is high.
- R8: A maskable request of level 0 is never accepted, even with `sr_mask` = 0.
- R9: `seq_done` sampled while the unit is idle has no effect: `entry_active` stays low and the next qualifying request is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_mask | input | 4 | Current interrupt mask field of the status register |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mi_req | input | 1 | Maskable interrupt request valid |
| mi_level | input | 4 | Priority level of the maskable request |
| mi_vector | input | VEC_W | Vector number of the maskable request |
| seq_done | input | 1 | Sequencer finished the state save and vector fetch |
| accept | output | 1 | One-cycle pulse: a request was taken |
| taken_nmi | output | 1 | Last accepted request was the non-maskable one |
| accept_vector | output | VEC_W | Vector number of the last accepted request |
| new_mask | output | 4 | Mask value to write back into the status register |
| entry_active | output | 1 | Save SR and PC, fetch vector, hold issue |

## Verification
The assertions check on every cycle that the accept pulse never lasts two cycles, and that nothing is accepted while entry is active. They also check that an idle non-maskable request is always taken with a saturated mask, and that a maskable acceptance always raised the mask above its previous value. Only the bench scenarios can show the strict comparison at the boundaries: equal level, level 0 and level 15 against mask 14. The same goes for the vector choice when both requests coincide, the holding of latched results across a busy period, and the harmlessness of a stray completion signal while idle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int MASK_W   = 4;
    localparam int MASK_TOP = (1 << MASK_W) - 1;

    typedef logic [MASK_W-1:0] irq_mask_t;

    typedef enum logic [0:0] {
        ENT_IDLE  = 1'b0,
        ENT_BUSY  = 1'b1
    } entry_state_e;

    typedef struct packed {
        logic      grant;
        logic      is_nmi;
        irq_mask_t next_mask;
    } irq_verdict_t;

    function automatic logic level_beats_mask(irq_mask_t lvl, irq_mask_t msk);
        return lvl > msk;
    endfunction

endpackage

// File: rtl/irq_mask_judge.sv
module irq_mask_judge
    import irq_accept_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int NMI_VECTOR = 11
) (
    input  irq_mask_t          cur_mask,
    input  logic               nmi_req,
    input  logic               mi_req,
    input  irq_mask_t          mi_level,
    input  logic [VEC_W-1:0]   mi_vector,
    output irq_verdict_t       verdict,
    output logic [VEC_W-1:0]   win_vector
);

    localparam logic [VEC_W-1:0] NMI_VEC_C = VEC_W'(NMI_VECTOR);

    logic mi_ok;

    always_comb begin
        mi_ok             = mi_req && level_beats_mask(mi_level, cur_mask);
        verdict.grant     = nmi_req || mi_ok;
        verdict.is_nmi    = nmi_req;
        verdict.next_mask = nmi_req ? irq_mask_t'(MASK_TOP) : mi_level;
        win_vector        = nmi_req ? NMI_VEC_C : mi_vector;
    end

    always_comb begin
        AST_ZERO_LEVEL_NEVER: assert (!(mi_ok && mi_level == '0)); // R8
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic seq_done,
    output logic take,
    output logic idle,
    output logic entry_active
);

    entry_state_e state_q, state_d;

    always_comb begin
        idle    = (state_q == ENT_IDLE);
        take    = idle && grant;
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE: if (grant)    state_d = ENT_BUSY;
            ENT_BUSY: if (seq_done) state_d = ENT_IDLE;
            default:                state_d = ENT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ENT_IDLE;
        else     state_q <= state_d;
    end

    assign entry_active = (state_q == ENT_BUSY);

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        entry_active && !seq_done |=> entry_active); // R7

    AST_IDLE_DONE_HARMLESS: assert property (@(posedge clk) disable iff (rst)
        !entry_active && !grant |=> !entry_active); // R9

endmodule

// File: rtl/irq_capture_regs.sv
module irq_capture_regs
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  irq_verdict_t       verdict,
    input  logic [VEC_W-1:0]   win_vector,
    output logic               accept,
    output logic               taken_nmi,
    output logic [VEC_W-1:0]   accept_vector,
    output irq_mask_t          new_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            accept        <= 1'b0;
            taken_nmi     <= 1'b0;
            accept_vector <= '0;
            new_mask      <= '0;
        end else begin
            accept <= take;
            if (take) begin
                taken_nmi     <= verdict.is_nmi;
                accept_vector <= win_vector;
                new_mask      <= verdict.next_mask;
            end
        end
    end

    AST_NMI_SATURATES: assert property (@(posedge clk) disable iff (rst)
        accept && taken_nmi |-> new_mask == irq_mask_t'(MASK_TOP)); // R4

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int NMI_VECTOR = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         sr_mask,
    input  logic               nmi_req,
    input  logic               mi_req,
    input  logic [3:0]         mi_level,
    input  logic [VEC_W-1:0]   mi_vector,
    input  logic               seq_done,
    output logic               accept,
    output logic               taken_nmi,
    output logic [VEC_W-1:0]   accept_vector,
    output logic [3:0]         new_mask,
    output logic               entry_active
);

    irq_verdict_t     verdict;
    logic [VEC_W-1:0] win_vector;
    logic             take;
    logic             idle;

    irq_mask_judge #(
        .VEC_W      (VEC_W),
        .NMI_VECTOR (NMI_VECTOR)
    ) u_judge (
        .cur_mask   (sr_mask),
        .nmi_req    (nmi_req),
        .mi_req     (mi_req),
        .mi_level   (mi_level),
        .mi_vector  (mi_vector),
        .verdict    (verdict),
        .win_vector (win_vector)
    );

    irq_entry_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .grant        (verdict.grant),
        .seq_done     (seq_done),
        .take         (take),
        .idle         (idle),
        .entry_active (entry_active)
    );

    irq_capture_regs #(
        .VEC_W (VEC_W)
    ) u_cap (
        .clk           (clk),
        .rst           (rst),
        .take          (take),
        .verdict       (verdict),
        .win_vector    (win_vector),
        .accept        (accept),
        .taken_nmi     (taken_nmi),
        .accept_vector (accept_vector),
        .new_mask      (new_mask)
    );

    AST_NMI_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        idle && nmi_req |=> accept && taken_nmi); // R2

    AST_MI_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        idle && mi_req && !nmi_req && mi_level <= sr_mask |=> !accept); // R3

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R6

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !accept |-> $stable(accept_vector) && $stable(new_mask) && $stable(taken_nmi)); // R6

    AST_ACCEPT_WITH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        accept |-> entry_active); // R7

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        entry_active |=> !accept); // R7

endmodule

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;

    localparam int VW  = 8;
    localparam int NMV = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    sr_mask = '0;
    logic          nmi_req = 1'b0;
    logic          mi_req = 1'b0;
    logic [3:0]    mi_level = '0;
    logic [VW-1:0] mi_vector = '0;
    logic          seq_done = 1'b0;
    logic          accept, taken_nmi, entry_active;
    logic [VW-1:0] accept_vector;
    logic [3:0]    new_mask;

    int checks = 0;
    int errors = 0;
    bit wd_fired = 1'b0;

    typedef struct {
        int    vec;
        int    msk;
        int    nmi;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    irq_accept_unit #(.VEC_W(VW), .NMI_VECTOR(NMV)) u0 (
        .clk(clk), .rst(rst), .sr_mask(sr_mask), .nmi_req(nmi_req),
        .mi_req(mi_req), .mi_level(mi_level), .mi_vector(mi_vector),
        .seq_done(seq_done), .accept(accept), .taken_nmi(taken_nmi),
        .accept_vector(accept_vector), .new_mask(new_mask),
        .entry_active(entry_active)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop one expected item per observed accept pulse
    always @(negedge clk) begin
        if (!rst && accept) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected accept", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(accept_vector) == e.vec, e.req, "vector", int'(accept_vector), e.vec);
                check(int'(new_mask) == e.msk, "R4", "new_mask", int'(new_mask), e.msk);
                check(int'(taken_nmi) == e.nmi, "R4", "taken_nmi", int'(taken_nmi), e.nmi);
            end
        end
    end

    // driver: present one request for one cycle, predict outcome
    task automatic attempt(bit nmi, bit mv, int lvl, int vec, int msk, string req);
        bit   exp_acc;
        exp_t e;
        @(negedge clk);
        sr_mask   = 4'(msk);
        nmi_req   = nmi;
        mi_req    = mv;
        mi_level  = 4'(lvl);
        mi_vector = VW'(vec);
        exp_acc   = nmi || (mv && lvl > msk);
        if (exp_acc) begin
            e.vec = nmi ? NMV : vec;
            e.msk = nmi ? 15 : lvl;
            e.nmi = nmi ? 1 : 0;
            e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
        nmi_req = 1'b0;
        mi_req  = 1'b0;
        check(accept == exp_acc, req, "accept", int'(accept), int'(exp_acc));
        check(entry_active == exp_acc, "R7", "entry_active at accept", int'(entry_active), int'(exp_acc));
    endtask

    task automatic finish_entry();
        @(negedge clk);
        check(accept == 1'b0, "R6", "pulse length", int'(accept), 0);
        check(entry_active == 1'b1, "R7", "entry held", int'(entry_active), 1);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        check(entry_active == 1'b0, "R7", "entry released", int'(entry_active), 0);
    endtask

    initial begin
        #50000;
        wd_fired = 1'b1;
    end

    initial begin : stim
        int keep_vec;
        int keep_msk;
        repeat (4) @(negedge clk);
        check(accept == 0 && entry_active == 0, "R1", "reset ctrl", int'(accept) + int'(entry_active), 0);
        check(accept_vector == 0 && new_mask == 0 && taken_nmi == 0, "R1", "reset data",
              int'(accept_vector) + int'(new_mask) + int'(taken_nmi), 0);
        rst = 1'b0;

        attempt(0, 1, 5, 40, 3, "R3");  finish_entry();
        attempt(0, 1, 3, 41, 3, "R3");
        attempt(0, 1, 2, 42, 3, "R3");
        attempt(0, 1, 0, 43, 0, "R8");
        attempt(0, 1, 15, 44, 14, "R3"); finish_entry();
        attempt(0, 1, 1, 45, 0, "R3");  finish_entry();
        attempt(1, 0, 0, 0, 15, "R2");  finish_entry();
        attempt(1, 1, 15, 46, 0, "R5"); finish_entry();

        // R6 / R7: results held and requests ignored while busy
        attempt(0, 1, 9, 77, 4, "R5");
        keep_vec = int'(accept_vector);
        keep_msk = int'(new_mask);
        @(negedge clk);
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        check(accept == 0, "R7", "no accept while busy", int'(accept), 0);
        check(int'(accept_vector) == keep_vec, "R6", "vector held", int'(accept_vector), keep_vec);
        check(int'(new_mask) == keep_msk, "R6", "mask held", int'(new_mask), keep_msk);
        finish_entry();
        @(negedge clk);
        check(accept == 0, "R7", "no late accept", int'(accept), 0);

        // R9: stray done while idle
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        @(negedge clk);
        check(entry_active == 0, "R9", "idle after stray done", int'(entry_active), 0);
        attempt(0, 1, 7, 88, 6, "R9"); finish_entry();

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge wd_fired) begin
        check(1'b0, "R7", "watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule